// File: doc/BRIEF.md
# Serial Peripheral Master with Per-Command Chip-Select Timing

This block is the timing engine of a single-channel serial peripheral master. Each accepted command moves one 8-bit word out on MOSI and one word in from MISO. The word is sent MSB first in SPI mode 0. The serial clock is derived from the system clock by a programmable divisor. Each command also carries two enable bits. The first chooses the lead interval, which runs from chip-select assertion to the first rising SCK edge. The second chooses the trailing gap, which runs from chip-select release until the next command may be taken. For each interval, the bit picks either a fixed default or a value from the configuration inputs. The trailing value counts in units of 32 system clocks.

The controller has four states. IDLE holds the command ready. On a valid command it moves to LEAD and asserts chip-select. When the lead count expires, LEAD moves to XFER. XFER toggles SCK for eight bit periods. After the low half of the eighth bit, XFER moves to POST and releases chip-select. When the gap expires, POST returns to IDLE and pulses done. The divisor, the chosen lead and the chosen gap are captured at the moment the command is accepted.

Top module: `spi_delay_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, done is 0 and cmd_ready is 1.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. cs_n is 0 in the following cycle. cmd_ready stays 0 from that cycle until the cycle in which done is 1.
- R3: Let D be cfg_div, with 0 and 1 treated as 2. Every SCK high phase and every SCK low phase lasts D system clocks, so the serial clock runs at the system clock divided by 2·D.
- R4: When cmd_clk_dly_en is 1 and cfg_lead is nonzero, the lead interval is cfg_lead system clocks. The lead interval is the number of cycles with cs_n at 0 before the first cycle with sck at 1.
- R5: When cmd_clk_dly_en is 0 or cfg_lead is 0, the lead interval is D system clocks, which is half a serial clock period.
- R6: cmd_data is shifted out MSB first. MOSI changes only on falling SCK edges, and SCK is low whenever cs_n is 1. cs_n stays at 0 for exactly lead + 16·D cycles.
- R7: rx_data holds the eight MISO bits sampled at the rising SCK edges, with the first sample in bit 7. It is valid in the cycle in which done is 1.
- R8: When cmd_post_dly_en is 1 and cfg_post is nonzero, cs_n stays at 1 for 32·cfg_post cycles after release before done is 1.
- R9: When cmd_post_dly_en is 0 or cfg_post is 0, that trailing gap is 17 cycles.
- R10: done is 1 for exactly one cycle, the cycle right after the gap. cmd_ready is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller is idle and takes a command |
| cmd_data | input | 8 | Word to transmit |
| cmd_clk_dly_en | input | 1 | Use the programmed lead interval |
| cmd_post_dly_en | input | 1 | Use the programmed trailing gap |
| cfg_div | input | 8 | Half-period divisor in system clocks |
| cfg_lead | input | 7 | Programmed lead interval in system clocks |
| cfg_post | input | 8 | Programmed trailing gap in units of 32 system clocks |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip-select, active low |
| rx_data | output | 8 | Received word |
| done | output | 1 | One-cycle pulse when the trailing gap ends |

## Verification
The bench sweeps the divisor over the values 0, 1, 2, 3 and 6. This separates the clamped values from the real ones and even periods from odd ones. The lead value is tried at 0, 1 and 9 with its enable both off and on. This separates the half-period default from a programmed count and catches the zero-field fallback. The trailing field is tried at 0, 1 and 2 with its enable both ways, and single runs use the largest lead and gap values. This separates the 17-cycle standard gap from the ×32 scaling. The transmit and receive words change on every command and differ from each other, so a bit-order fault, a mirrored word or a lane swap shows up as a data mismatch.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_XFER,
        S_POST
    } spi_dm_state_e;

    localparam int unsigned POST_SHIFT = 5;   // gap unit of 32 clocks
    localparam int unsigned STD_POST   = 17;  // standard trailing gap
    localparam int unsigned MIN_DIV    = 2;
endpackage

// File: rtl/spi_dm_timer.sv
module spi_dm_timer #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == CNT_W'(1));

    // a countdown never runs past zero: an expiring count reaches zero next
    p_expire_then_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (cnt == '0));
endmodule

// File: rtl/spi_dm_shift.sv
module spi_dm_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [DATA_W-1:0] rx
);
    logic [DATA_W-1:0] tx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx <= '0;
            rx <= '0;
        end else begin
            if (load) begin
                tx <= load_data;
            end else if (fall) begin
                tx <= {tx[DATA_W-2:0], 1'b0};
            end
            if (rise) begin
                rx <= {rx[DATA_W-2:0], miso};
            end
        end
    end

    assign mosi_bit = tx[DATA_W-1];

    // edges of the serial clock never coincide
    p_rise_fall_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/spi_delay_master.sv
module spi_delay_master
    import spi_dm_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned LEAD_W = 7,
    parameter int unsigned POST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_clk_dly_en,
    input  logic              cmd_post_dly_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LEAD_W-1:0] cfg_lead,
    input  logic [POST_W-1:0] cfg_post,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);
    localparam int unsigned CNT_W = POST_W + POST_SHIFT;
    localparam int unsigned BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    spi_dm_state_e    state, nxt;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic [DIV_W-1:0] div_in, div_l;
    logic [CNT_W-1:0] lead_in, gap_in, gap_l;
    logic [BIT_W-1:0] bitcnt;
    logic             sck_q, done_q, accept, rise, fall, mosi_bit;

    assign accept  = (state == S_IDLE) && cmd_valid;
    assign div_in  = (cfg_div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : cfg_div;
    assign lead_in = (cmd_clk_dly_en && cfg_lead != '0) ? CNT_W'(cfg_lead)
                                                        : CNT_W'(div_in);
    assign gap_in  = (cmd_post_dly_en && cfg_post != '0)
                   ? {cfg_post, {POST_SHIFT{1'b0}}} : CNT_W'(STD_POST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state and timer reload
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(div_l);
        rise     = 1'b0;
        fall     = 1'b0;
        unique case (state)
            S_IDLE: if (cmd_valid) begin
                nxt      = S_LEAD;
                tmr_load = 1'b1;
                tmr_val  = lead_in;
            end
            S_LEAD: if (tmr_exp) begin
                nxt      = S_XFER;
                tmr_load = 1'b1;
                rise     = 1'b1;
            end
            S_XFER: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (sck_q) begin
                    fall = 1'b1;
                end else if (bitcnt == LAST_BIT) begin
                    nxt     = S_POST;
                    tmr_val = gap_l;
                end else begin
                    rise = 1'b1;
                end
            end
            S_POST: if (tmr_exp) nxt = S_IDLE;
        endcase
    end

    // outputs and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            done_q <= 1'b0;
            bitcnt <= '0;
            div_l  <= DIV_W'(MIN_DIV);
            gap_l  <= CNT_W'(STD_POST);
        end else begin
            done_q <= (state == S_POST) && tmr_exp;
            if (accept) begin
                div_l  <= div_in;
                gap_l  <= gap_in;
                bitcnt <= '0;
            end
            if (rise) begin
                sck_q <= 1'b1;
                if (state == S_XFER) bitcnt <= bitcnt + 1'b1;
            end else if (fall) begin
                sck_q <= 1'b0;
            end
        end
    end

    spi_dm_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    spi_dm_shift #(.DATA_W(DATA_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (cmd_data),
        .rise      (rise),
        .fall      (fall),
        .miso      (miso),
        .mosi_bit  (mosi_bit),
        .rx        (rx_data)
    );

    assign cs_n      = !((state == S_LEAD) || (state == S_XFER));
    assign cmd_ready = (state == S_IDLE);
    assign sck       = sck_q;
    assign mosi      = cs_n ? 1'b0 : mosi_bit;
    assign done      = done_q;

    p_ready_cs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> cs_n);
    p_sck_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
    p_release_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !sck);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);
endmodule

// File: tb/spi_delay_master_tb_top.sv
module spi_delay_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [7:0] cmd_data = '0;
    logic       cmd_clk_dly_en = 1'b0;
    logic       cmd_post_dly_en = 1'b0;
    logic [7:0] cfg_div = '0;
    logic [6:0] cfg_lead = '0;
    logic [7:0] cfg_post = '0;
    logic       sck, mosi, miso, cs_n, done;
    logic [7:0] rx_data;

    logic [7:0] slv_tx = '0;
    logic [7:0] slv_rx = '0;
    logic [2:0] nfall = '0;

    int errors = 0;
    int checks = 0;
    bit wd_hit = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    spi_delay_master dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_valid       (cmd_valid),
        .cmd_ready       (cmd_ready),
        .cmd_data        (cmd_data),
        .cmd_clk_dly_en  (cmd_clk_dly_en),
        .cmd_post_dly_en (cmd_post_dly_en),
        .cfg_div         (cfg_div),
        .cfg_lead        (cfg_lead),
        .cfg_post        (cfg_post),
        .sck             (sck),
        .mosi            (mosi),
        .miso            (miso),
        .cs_n            (cs_n),
        .rx_data         (rx_data),
        .done            (done)
    );

    // mode 0 slave model
    always @(posedge sck) slv_rx <= {slv_rx[6:0], mosi};
    always @(negedge sck or posedge cs_n) begin
        if (cs_n) nfall <= '0;
        else      nfall <= nfall + 3'd1;
    end
    assign miso = slv_tx[3'd7 - nfall];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic xfer(input int div, input int lead, input bit len,
                        input int post, input bit pen, input logic [7:0] data,
                        input logic [7:0] stx);
        int d, l, g, n, lead_cnt, low_cnt, gap, hi_run, bad_hi, ready_bad, first_cs;
        bit seen_sck;
        d = (div < 2) ? 2 : div;
        l = (len && lead != 0) ? lead : d;
        g = (pen && post != 0) ? 32 * post : 17;
        cfg_div = 8'(div); cfg_lead = 7'(lead); cfg_post = 8'(post);
        cmd_clk_dly_en = len; cmd_post_dly_en = pen;
        cmd_data = data; slv_tx = stx;
        @(negedge clk); cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        first_cs = int'(cs_n);
        lead_cnt = 0; low_cnt = 0; gap = 0; hi_run = 0; bad_hi = 0;
        ready_bad = 0; n = 0; seen_sck = 1'b0;
        while (!done && n < 20000) begin
            if (!cs_n) begin
                low_cnt++;
                if (!seen_sck && !sck) lead_cnt++;
            end else begin
                gap++;
            end
            if (sck) begin
                seen_sck = 1'b1;
                hi_run++;
            end else if (hi_run != 0) begin
                if (hi_run != d) bad_hi++;
                hi_run = 0;
            end
            if (cmd_ready) ready_bad++;
            @(negedge clk); n++;
        end
        chk(first_cs == 0, "R2 cs_n low after accept", first_cs, 0);
        chk(ready_bad == 0, "R2 ready low while busy", ready_bad, 0);
        chk(bad_hi == 0, "R3 sck high phase width", bad_hi, 0);
        if (len && lead != 0) chk(lead_cnt == l, "R4 programmed lead", lead_cnt, l);
        else                  chk(lead_cnt == l, "R5 default lead", lead_cnt, l);
        chk(low_cnt == l + 16 * d, "R6 cs low length", low_cnt, l + 16 * d);
        chk(slv_rx == data, "R6 mosi word", int'(slv_rx), int'(data));
        chk(rx_data == stx, "R7 rx word", int'(rx_data), int'(stx));
        if (pen && post != 0) chk(gap == g, "R8 programmed gap", gap, g);
        else                  chk(gap == g, "R9 standard gap", gap, g);
        chk(cmd_ready == 1'b1, "R10 ready with done", int'(cmd_ready), 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    task automatic run_all();
        int idx;
        int divs[5] = '{0, 1, 2, 3, 6};
        int leads[3] = '{0, 1, 9};
        idx = 0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n reset", int'(cs_n), 1);
        chk(sck == 1'b0, "R1 sck reset", int'(sck), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        chk(cmd_ready == 1'b1, "R1 ready reset", int'(cmd_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        foreach (divs[i]) foreach (leads[j])
            for (int le = 0; le < 2; le++)
                for (int pe = 0; pe < 2; pe++)
                    for (int po = 0; po < 3; po++) begin
                        xfer(divs[i], leads[j], le[0], po, pe[0],
                             8'(idx * 37 + 5), 8'(8'hA5 ^ (idx * 11)));
                        idx++;
                    end
        xfer(4, 127, 1'b1, 255, 1'b1, 8'h81, 8'h7E);
        xfer(255, 0, 1'b0, 0, 1'b1, 8'h3C, 8'hC3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) chk(1'b0, "watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule